// File: doc/BRIEF.md
# Accumulator Quad-Group Row Sequencer

This block turns one multi-vector widening accumulate request into an ordered list of access steps. It serves a datapath that adds byte-element products into rows of a two-dimensional accumulator array. Each request names the group count (two or four members) and the fields that pick the two source register groups. It also carries an immediate offset bit, a register-select field and the 32-bit value read from the selected index register. From these the block finds a starting row that is aligned to four rows. It then walks the array partitions one row stride at a time, making four row updates in each partition.

Each step gives the datapath five things: the two source vector register numbers, the accumulator row to update, the byte lane, and a flag that marks the final step. The byte lane L means that 32-bit accumulator element e takes source byte 4*e+L from both source vectors. The steps leave the block over a valid/ready stream. A step is accepted on a cycle where `step_valid_o` and `step_ready_i` are both high. While ready is low, the step on offer stays unchanged. Ready may be high or low on any cycle, and the block never makes valid depend on ready. A request starts with a plain `start_i` pulse. `busy_o` covers the whole walk, and `done_o` pulses once at the end.

Top module: `qg_row_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `step_valid_o` are low.
- R2: A `start_i` seen while idle is captured. On the next cycle `busy_o` is high and `step_valid_o` offers the first step.
- R3: A request yields 4*count steps, where count is 2 when `quad_i`=0 and 4 when `quad_i`=1. Step k has member r = k/4 and update i = k mod 4. `step_lane_o` equals i, so element e uses source byte 4*e+i.
- R4: Member r reads source registers n+r and m+r. In pair mode n = 2*`zn_i` and m = 2*`zm_i`, using all four field bits. In quad mode n = 4*`zn_i[2:0]` and m = 4*`zm_i[2:0]`.
- R5: The start row is ((`base_i` + 4*`off_i`) mod stride), rounded down to a multiple of 4. Step (r,i) updates row start + r*stride + i, so the low two bits of the row always equal the lane.
- R6: The stride is (VL_BITS/8)/count rows.
- R7: While `step_valid_o` is high and `step_ready_i` is low, every step output holds its value. The walk advances only on an accepted step.
- R8: `done_o` is high for exactly one cycle, the cycle after the final step is accepted. In that cycle `busy_o` and `step_valid_o` are low.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The steps in progress and `idx_reg_o` do not change.
- R10: `idx_reg_o` shows 8 plus the `rv_i` field captured at the accepted start. It stays at 8 after reset until the first start.
- R11: `step_last_o` is high only on the final step of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| quad_i | input | 1 | Group count select: 0 = two members, 1 = four members |
| base_i | input | 32 | Value of the selected index register |
| off_i | input | 1 | Immediate offset bit (offset = 4*off_i) |
| rv_i | input | 2 | Index register select field |
| zn_i | input | 4 | First source group field |
| zm_i | input | 4 | Second source group field |
| busy_o | output | 1 | High while a request is being walked |
| done_o | output | 1 | One-cycle pulse after the final step is accepted |
| idx_reg_o | output | 4 | Index register number (8 + rv field) |
| step_valid_o | output | 1 | A step is on offer |
| step_ready_i | input | 1 | Downstream accepts the step on offer |
| step_src_a_o | output | 5 | First source vector register number |
| step_src_b_o | output | 5 | Second source vector register number |
| step_row_o | output | log2(VL_BITS/8) | Accumulator row to update |
| step_lane_o | output | 2 | Byte lane: element e uses source byte 4*e+lane |
| step_last_o | output | 1 | Marks the final step of the request |

## Verification
The bench sweeps both group counts, both offset bits, several index-register values and several source fields. The index values include ones near the top of the 32-bit range, ones that are not multiples of four, and ones that sit just below or on a stride boundary. Together these separate a wrong modulus, a missing round-down and a wrong stride. Each sweep runs under three ready patterns: always ready, ready on alternate cycles, and ready one cycle in three. These show whether a step moves or repeats when it is stalled, and whether `done_o` lines up with the last accepted step. One request receives a second `start_i` part way through its walk, to show that a start while busy leaves both the step list and the index register output unchanged.

// File: rtl/qg_pkg.sv
package qg_pkg;
  localparam int SRC_W  = 5;
  localparam int LANE_W = 2;

  typedef enum logic {
    GRP_PAIR = 1'b0,
    GRP_QUAD = 1'b1
  } grp_e;

  typedef struct packed {
    logic [1:0] member;
    logic [1:0] lane;
  } step_pos_t;
endpackage

// File: rtl/qg_cfg_decode.sv
module qg_cfg_decode
  import qg_pkg::*;
#(
  parameter int VL_BITS = 512,
  localparam int ROWS  = VL_BITS / 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  grp_e              grp,
  input  logic [31:0]       base,
  input  logic              off,
  input  logic [1:0]        rv,
  input  logic [3:0]        zn,
  input  logic [3:0]        zm,
  output logic [ROW_W-1:0]  stride,
  output logic [ROW_W-1:0]  start_row,
  output logic [SRC_W-1:0]  n_base,
  output logic [SRC_W-1:0]  m_base,
  output logic [3:0]        idx_reg,
  output logic [1:0]        last_member
);
  localparam logic [ROW_W-1:0] STRIDE_PAIR = ROW_W'(ROWS / 2);
  localparam logic [ROW_W-1:0] STRIDE_QUAD = ROW_W'(ROWS / 4);

  logic [32:0]      sum_full;
  logic [ROW_W-1:0] sum_low;
  logic [ROW_W-1:0] mask;

  always_comb begin
    stride    = (grp == GRP_QUAD) ? STRIDE_QUAD : STRIDE_PAIR;
    mask      = stride - ROW_W'(1);
    sum_full  = {1'b0, base} + {30'd0, off, 2'b00};
    sum_low   = sum_full[ROW_W-1:0];
    start_row = sum_low & mask & ~ROW_W'(3);
    if (grp == GRP_QUAD) begin
      n_base      = {zn[2:0], 2'b00};
      m_base      = {zm[2:0], 2'b00};
      last_member = 2'd3;
    end else begin
      n_base      = {zn, 1'b0};
      m_base      = {zm, 1'b0};
      last_member = 2'd1;
    end
    idx_reg = {2'b10, rv};
  end
endmodule

// File: rtl/qg_step_ctr.sv
module qg_step_ctr
  import qg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      launch,
  input  logic      advance,
  input  logic [1:0] last_member,
  output logic      busy,
  output logic      done,
  output step_pos_t pos,
  output logic      last_step
);
  assign last_step = busy && (pos.member == last_member) && (pos.lane == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      pos  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (launch) begin
          busy <= 1'b1;
          pos  <= '0;
        end
      end else if (advance) begin
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pos.lane <= pos.lane + 2'd1;
          if (pos.lane == 2'd3) pos.member <= pos.member + 2'd1;
        end
      end
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && advance) |=> (done && !busy));
endmodule

// File: rtl/qg_row_seq.sv
module qg_row_seq
  import qg_pkg::*;
#(
  parameter int VL_BITS = 512,
  localparam int ROWS  = VL_BITS / 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             quad_i,
  input  logic [31:0]      base_i,
  input  logic             off_i,
  input  logic [1:0]       rv_i,
  input  logic [3:0]       zn_i,
  input  logic [3:0]       zm_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [3:0]       idx_reg_o,
  output logic             step_valid_o,
  input  logic             step_ready_i,
  output logic [4:0]       step_src_a_o,
  output logic [4:0]       step_src_b_o,
  output logic [ROW_W-1:0] step_row_o,
  output logic [1:0]       step_lane_o,
  output logic             step_last_o
);
  grp_e             grp_in;
  logic [ROW_W-1:0] dec_stride, dec_start;
  logic [SRC_W-1:0] dec_n, dec_m;
  logic [3:0]       dec_idx;
  logic [1:0]       dec_last;

  logic [ROW_W-1:0] stride_q, row_q;
  logic [SRC_W-1:0] src_a_q, src_b_q;
  logic [3:0]       idx_q;
  logic [1:0]       last_q;

  logic      busy, done, last_step, launch, advance;
  step_pos_t pos;

  assign grp_in  = grp_e'(quad_i);
  assign launch  = start_i && !busy;
  assign advance = busy && step_ready_i;

  qg_cfg_decode #(.VL_BITS(VL_BITS)) u_dec (
    .grp(grp_in), .base(base_i), .off(off_i), .rv(rv_i),
    .zn(zn_i), .zm(zm_i),
    .stride(dec_stride), .start_row(dec_start),
    .n_base(dec_n), .m_base(dec_m),
    .idx_reg(dec_idx), .last_member(dec_last)
  );

  qg_step_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .advance(advance),
    .last_member(last_q), .busy(busy), .done(done),
    .pos(pos), .last_step(last_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0;
      row_q    <= '0;
      src_a_q  <= '0;
      src_b_q  <= '0;
      idx_q    <= 4'd8;
      last_q   <= 2'd1;
    end else if (launch) begin
      stride_q <= dec_stride;
      row_q    <= dec_start;
      src_a_q  <= dec_n;
      src_b_q  <= dec_m;
      idx_q    <= dec_idx;
      last_q   <= dec_last;
    end else if (advance && !last_step) begin
      if (pos.lane == 2'd3) begin
        row_q   <= row_q + stride_q - ROW_W'(3);
        src_a_q <= src_a_q + SRC_W'(1);
        src_b_q <= src_b_q + SRC_W'(1);
      end else begin
        row_q <= row_q + ROW_W'(1);
      end
    end
  end

  assign busy_o       = busy;
  assign done_o       = done;
  assign idx_reg_o    = idx_q;
  assign step_valid_o = busy;
  assign step_src_a_o = src_a_q;
  assign step_src_b_o = src_b_q;
  assign step_row_o   = row_q;
  assign step_lane_o  = pos.lane;
  assign step_last_o  = last_step;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid_o && !step_ready_i) |=> (step_valid_o && $stable(step_row_o)
      && $stable(step_src_a_o) && $stable(step_src_b_o) && $stable(step_lane_o)));

  // R5
  row_lane_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_o |-> (step_row_o[1:0] == step_lane_o));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(idx_reg_o));

  // R2
  launch_offers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (step_valid_o && step_lane_o == 2'd0));

  // R3
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid_o && step_ready_i && !step_last_o) |=>
      (step_lane_o == $past(step_lane_o) + 2'd1));
endmodule

// File: tb/qg_row_seq_tb.sv
module qg_row_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VL   = 512;
  localparam int ROWS = VL / 8;
  localparam int RW   = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, quad_i = 1'b0, off_i = 1'b0, step_ready_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [1:0] rv_i = '0;
  logic [3:0] zn_i = '0, zm_i = '0;
  logic busy_o, done_o, step_valid_o, step_last_o;
  logic [3:0] idx_reg_o;
  logic [4:0] step_src_a_o, step_src_b_o;
  logic [RW-1:0] step_row_o;
  logic [1:0] step_lane_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qg_row_seq #(.VL_BITS(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .quad_i(quad_i),
    .base_i(base_i), .off_i(off_i), .rv_i(rv_i), .zn_i(zn_i), .zm_i(zm_i),
    .busy_o(busy_o), .done_o(done_o), .idx_reg_o(idx_reg_o),
    .step_valid_o(step_valid_o), .step_ready_i(step_ready_i),
    .step_src_a_o(step_src_a_o), .step_src_b_o(step_src_b_o),
    .step_row_o(step_row_o), .step_lane_o(step_lane_o),
    .step_last_o(step_last_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input bit quad, input logic [31:0] base, input bit off,
                        input logic [1:0] rv, input logic [3:0] zn,
                        input logic [3:0] zm, input int pat, input bit poke);
    int count, stride, start, n, m, total, k, guard;
    longint sum;
    bit rdy;
    count  = quad ? 4 : 2;
    stride = ROWS / count;                                // R6
    sum    = longint'(base) + (off ? 4 : 0);
    start  = int'(sum % stride);
    start  = start - (start % 4);                         // R5
    n      = quad ? int'(zn[2:0]) * 4 : int'(zn) * 2;     // R4
    m      = quad ? int'(zm[2:0]) * 4 : int'(zm) * 2;
    total  = 4 * count;
    k = 0;
    guard = 0;
    @(negedge clk);
    quad_i = quad; base_i = base; off_i = off; rv_i = rv; zn_i = zn; zm_i = zm;
    start_i = 1'b1;
    step_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    quad_i = ~quad; base_i = ~base; rv_i = ~rv; zn_i = ~zn; zm_i = ~zm;
    chk("R2 busy after start", busy_o, 1);
    chk("R2 valid after start", step_valid_o, 1);
    chk("R10 idx reg", idx_reg_o, 8 + rv);
    forever begin
      if (done_o) begin
        chk("R8 done after last step", k, total);
        chk("R8 busy low at done", busy_o, 0);
        chk("R8 valid low at done", step_valid_o, 0);
        break;
      end
      if (!step_valid_o || guard > 200) begin
        chk("R3 walk ended early", k, total);
        break;
      end
      guard++;
      case (pat)
        0: rdy = 1'b1;
        1: rdy = cyc[0];
        default: rdy = (cyc % 3) == 0;
      endcase
      if (poke && k == 2) start_i = 1'b1;                 // R9 start while busy
      else start_i = 1'b0;
      step_ready_i = rdy;
      if (rdy) begin
        chk("R3 lane", step_lane_o, k % 4);
        chk("R4 src a", step_src_a_o, n + k / 4);
        chk("R4 src b", step_src_b_o, m + k / 4);
        chk("R5 row", step_row_o, start + (k / 4) * stride + k % 4);
        chk("R11 last flag", step_last_o, (k == total - 1) ? 1 : 0);
        if (poke) chk("R9 idx reg unchanged", idx_reg_o, 8 + rv);
        k++;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    step_ready_i = 1'b0;
    @(negedge clk);
    chk("R8 done single pulse", done_o, 0);
    chk("R9 no restart from busy start", busy_o, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] bases [6];
    bases[0] = 32'd0;
    bases[1] = 32'd5;
    bases[2] = 32'd15;
    bases[3] = 32'd31;
    bases[4] = 32'hFFFF_FFFD;
    bases[5] = 32'h1234_5677;
    repeat (3) @(negedge clk);
    chk("R1 busy reset", busy_o, 0);
    chk("R1 done reset", done_o, 0);
    chk("R1 valid reset", step_valid_o, 0);
    chk("R10 idx reset", idx_reg_o, 8);
    rst_n = 1'b1;
    @(negedge clk);
    for (int q = 0; q < 2; q++)
      for (int b = 0; b < 6; b++)
        for (int o = 0; o < 2; o++)
          run_op(q[0], bases[b], o[0], 2'(b + o), 4'(b * 3 + q),
                 4'(15 - b), (b + o) % 3, 1'b0);
    run_op(1'b1, 32'd47, 1'b1, 2'd3, 4'd7, 4'd2, 1, 1'b1);
    run_op(1'b0, 32'd29, 1'b0, 2'd1, 4'd15, 4'd0, 2, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule